// File: doc/BRIEF.md
# Configuration Header Sync and Byte-Order Detector

This block watches an incoming byte stream for the fixed 13-word preamble that opens a device configuration image. It slides a four-byte window across the stream one byte at a time, and the first window that reads all-ones starts one attempt to match the whole preamble. During that attempt it works out whether the image stores its 32-bit words byte-reversed. When the attempt ends, it reports whether a usable header was found, whether the words are swapped, and the byte offset at which the header began. An image is accepted only if its header starts at byte offset zero.

After an accepted header, the block packs each following group of four bytes into a 32-bit word in the corrected byte order and emits it on a word output. The `in_sof` pulse clears all results and starts a fresh scan. The input handshake stalls only during that pulse and after an attempt has ended without a usable header.

Top module: `hsd_sync_detect`

## Requirements
- R1: After reset, and in the cycle after an `in_sof` pulse, `res_done`, `res_found`, `res_swapped` and `out_valid` are 0. After reset `in_ready` is 1.
- R2: The expected header is word 0 to 7 = 0xFFFFFFFF, word 8 = 0x000000BB, word 9 = 0x11220044, word 10 and 11 = 0xFFFFFFFF, word 12 = 0xAA995566. When every word matches, `res_done` and `res_found` rise in the cycle after the last header byte is accepted. `res_found` is never 1 without `res_done`.
- R3: In normal order, the first byte of each group of four is the most significant byte of the word. An all-ones filler word never switches the detector to swapped mode, so `res_swapped` stays 0 through words 0 to 7.
- R4: A non-filler header word whose byte-reversed value equals the expected word sets `res_swapped` in the cycle after its last byte. From then on, groups are assembled with the first byte as the least significant byte.
- R5: A header word that matches neither directly nor byte-reversed sets `res_done` with `res_found` = 0 in the cycle after that word's last byte. From then on `in_ready` is 0 until `in_sof`.
- R6: The scan tests every byte offset. `res_offset` reports the offset of the first all-ones window. A full header match at a nonzero offset gives `res_found` = 0 and produces no output words.
- R7: Only one attempt is made, at the first all-ones window. A mismatch later in that attempt ends the search.
- R8: After an accepted header, each complete group of four bytes produces a one-cycle `out_valid` in the cycle after its fourth byte. `out_data` is in normal order, or byte-reversed when `res_swapped` is 1. A trailing partial group is dropped.
- R9: `res_done`, `res_found` and `res_swapped` hold their values until the next `in_sof`.
- R10: If `in_last` arrives before all 13 header words have matched, the block reports `res_done` = 1 and `res_found` = 0 in the cycle after that byte.
- R11: While `in_sof` is high, `in_ready` is 0 and the byte offered in that cycle is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the byte this cycle |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Start-of-image pulse: clears results and restarts the scan |
| in_last | input | 1 | Marks the final byte of the image |
| res_done | output | 1 | Header attempt finished |
| res_found | output | 1 | Header accepted at offset zero |
| res_swapped | output | 1 | Image words are byte-reversed |
| res_offset | output | OFS_W | Byte offset of the first all-ones window |
| out_valid | output | 1 | Corrected payload word valid (one cycle) |
| out_data | output | 32 | Corrected payload word |

## Verification
Every result is a single register stage behind the byte that decides it. A header success or failure, a swap detection and a payload word each become visible in the cycle after the deciding byte is accepted. The bench drives one byte per cycle and, for each run, records the index of the byte after which `res_done` and `res_swapped` first read 1. It compares these indices with values worked out arithmetically from the offset and the word position, for example offset + 4·word + 3. Output words are sampled half a cycle after the edge on which they appear.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

  localparam int HDR_LEN = 13;
  localparam logic [31:0] FILL_WORD = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    ST_SCAN,
    ST_MATCH,
    ST_STREAM,
    ST_HALT
  } hsd_state_e;

  // Expected preamble word by position.
  function automatic logic [31:0] hdr_word(input logic [3:0] idx);
    case (idx)
      4'd8:    hdr_word = 32'h0000_00BB;
      4'd9:    hdr_word = 32'h1122_0044;
      4'd12:   hdr_word = 32'hAA99_5566;
      default: hdr_word = FILL_WORD;
    endcase
  endfunction

  function automatic logic [31:0] byte_rev(input logic [31:0] w);
    byte_rev = {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/hsd_word_asm.sv
module hsd_word_asm #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic [BYTE_W*(LANES-1)-1:0] hist,
  input  logic [BYTE_W-1:0]           byte_in,
  input  logic                        rev_en,
  output logic [BYTE_W*LANES-1:0]     nat_word,
  output logic [BYTE_W*LANES-1:0]     fix_word
);

  localparam int WORD_W = BYTE_W * LANES;

  logic [WORD_W-1:0] rev_word;

  // oldest byte lands in the most significant lane
  assign nat_word = {hist, byte_in};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rev_word[g*BYTE_W +: BYTE_W] = nat_word[(LANES-1-g)*BYTE_W +: BYTE_W];
  end

  assign fix_word = rev_en ? rev_word : nat_word;

endmodule

// File: rtl/hsd_word_cmp.sv
module hsd_word_cmp
  import hsd_pkg::*;
(
  input  logic [31:0] cand,
  input  logic [31:0] expw,
  output logic        take_rev,
  output logic        match
);

  logic [31:0] rev_cand;

  assign rev_cand = byte_rev(cand);
  // a filler word is its own reversal, so it can never select swapped order
  assign take_rev = (rev_cand != FILL_WORD) && (rev_cand == expw);
  assign match    = take_rev || (cand == expw);

endmodule

// File: rtl/hsd_sync_detect.sv
module hsd_sync_detect
  import hsd_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_last,
  output logic             res_done,
  output logic             res_found,
  output logic             res_swapped,
  output logic [OFS_W-1:0] res_offset,
  output logic             out_valid,
  output logic [31:0]      out_data
);

  localparam logic [OFS_W-1:0] CNT_MAX  = '1;
  localparam logic [OFS_W-1:0] WIN_SPAN = OFS_W'(3);
  localparam logic [3:0]       LAST_IDX = 4'(HDR_LEN - 1);

  // reset synchronizer
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  hsd_state_e       state_q, state_d;
  logic [3:0]       widx_q, widx_d;
  logic [1:0]       bcnt_q, bcnt_d;
  logic [23:0]      win_q, win_d;
  logic [OFS_W-1:0] cnt_q, cnt_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic             swap_q, swap_d;
  logic             done_q, done_d;
  logic             found_q, found_d;
  logic             ovld_q, ovld_d;
  logic [31:0]      odata_q, odata_d;

  logic        take, upd_en, ones_hit, group_full;
  logic [31:0] nat_word, fix_word;
  logic        take_rev, hdr_match;

  assign in_ready   = !in_sof && (state_q != ST_HALT);
  assign take       = in_valid && in_ready;
  assign upd_en     = take || in_sof;
  assign group_full = (bcnt_q == 2'd3);

  hsd_word_asm #(.BYTE_W(8), .LANES(4)) u_asm (
    .hist     (win_q),
    .byte_in  (in_data),
    .rev_en   (swap_q),
    .nat_word (nat_word),
    .fix_word (fix_word)
  );

  hsd_word_cmp u_cmp (
    .cand     (fix_word),
    .expw     (hdr_word(widx_q)),
    .take_rev (take_rev),
    .match    (hdr_match)
  );

  assign ones_hit = (nat_word == FILL_WORD) && (cnt_q >= WIN_SPAN);

  always_comb begin
    state_d = state_q;
    widx_d  = widx_q;
    bcnt_d  = bcnt_q;
    win_d   = win_q;
    cnt_d   = cnt_q;
    ofs_d   = ofs_q;
    swap_d  = swap_q;
    done_d  = done_q;
    found_d = found_q;
    ovld_d  = 1'b0;
    odata_d = odata_q;
    if (in_sof) begin
      state_d = ST_SCAN;
      widx_d  = '0;
      bcnt_d  = '0;
      cnt_d   = '0;
      ofs_d   = '0;
      swap_d  = 1'b0;
      done_d  = 1'b0;
      found_d = 1'b0;
    end else if (take) begin
      win_d = nat_word[23:0];
      unique case (state_q)
        ST_SCAN: begin
          if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
          if (ones_hit) begin
            ofs_d   = cnt_q - WIN_SPAN;
            widx_d  = 4'd1;
            bcnt_d  = '0;
            state_d = ST_MATCH;
          end
          if (in_last) begin
            done_d  = 1'b1;
            found_d = 1'b0;
            state_d = ST_HALT;
          end
        end
        ST_MATCH: begin
          bcnt_d = bcnt_q + 1'b1;
          if (group_full && !hdr_match) begin
            done_d  = 1'b1;
            found_d = 1'b0;
            state_d = ST_HALT;
          end else if (group_full && widx_q == LAST_IDX) begin
            swap_d  = swap_q | take_rev;
            done_d  = 1'b1;
            found_d = (ofs_q == '0);
            state_d = ((ofs_q == '0) && !in_last) ? ST_STREAM : ST_HALT;
          end else begin
            if (group_full) begin
              swap_d = swap_q | take_rev;
              widx_d = widx_q + 1'b1;
            end
            if (in_last) begin
              done_d  = 1'b1;
              found_d = 1'b0;
              state_d = ST_HALT;
            end
          end
        end
        ST_STREAM: begin
          bcnt_d = bcnt_q + 1'b1;
          if (group_full) begin
            ovld_d  = 1'b1;
            odata_d = fix_word;
          end
          if (in_last) state_d = ST_HALT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= ST_SCAN;
      widx_q  <= '0;
      bcnt_q  <= '0;
      win_q   <= '0;
      cnt_q   <= '0;
      ofs_q   <= '0;
      swap_q  <= 1'b0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      ovld_q  <= 1'b0;
      odata_q <= '0;
    end else begin
      ovld_q <= ovld_d;
      if (upd_en) begin
        state_q <= state_d;
        widx_q  <= widx_d;
        bcnt_q  <= bcnt_d;
        win_q   <= win_d;
        cnt_q   <= cnt_d;
        ofs_q   <= ofs_d;
        swap_q  <= swap_d;
        done_q  <= done_d;
        found_q <= found_d;
        odata_q <= odata_d;
      end
    end
  end

  assign res_done    = done_q;
  assign res_found   = found_q;
  assign res_swapped = swap_q;
  assign res_offset  = ofs_q;
  assign out_valid   = ovld_q;
  assign out_data    = odata_q;

endmodule

// File: rtl/hsd_sync_detect_chk.sv
module hsd_sync_detect_chk #(
  parameter int OFS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_sof,
  input logic             in_ready,
  input logic             res_done,
  input logic             res_found,
  input logic             res_swapped,
  input logic [OFS_W-1:0] res_offset,
  input logic             out_valid
);

  assert_found_has_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_found |-> res_done);

  assert_found_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_found |-> (res_offset == '0));

  assert_halt_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && !res_found) |-> !in_ready);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && !in_sof) |=> (res_done && $stable(res_found) && $stable(res_swapped)));

  assert_sof_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_sof |=> (!res_done && !res_swapped && !out_valid));

  assert_word_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_stream_after_found_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> res_found);

  assert_sof_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_sof |-> !in_ready);

endmodule

bind hsd_sync_detect hsd_sync_detect_chk #(.OFS_W(OFS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .in_sof      (in_sof),
  .in_ready    (in_ready),
  .res_done    (res_done),
  .res_found   (res_found),
  .res_swapped (res_swapped),
  .res_offset  (res_offset),
  .out_valid   (out_valid)
);

// File: tb/hsd_sync_detect_tb.sv
`timescale 1ns/1ps
module hsd_sync_detect_tb;

  localparam int OFS_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid, in_ready, in_sof, in_last;
  logic [7:0]       in_data;
  logic             res_done, res_found, res_swapped, out_valid;
  logic [OFS_W-1:0] res_offset;
  logic [31:0]      out_data;

  always #10 clk = ~clk;

  hsd_sync_detect #(.OFS_W(OFS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_last(in_last),
    .res_done(res_done), .res_found(res_found), .res_swapped(res_swapped),
    .res_offset(res_offset), .out_valid(out_valid), .out_data(out_data)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0]  stim [0:127];
  int          n_stim;
  logic [31:0] got [0:15];
  int          n_got;
  int          done_at, swap_at;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_hdr(input int i);
    if (i == 8)  return 32'h0000_00BB;
    if (i == 9)  return 32'h1122_0044;
    if (i == 12) return 32'hAA99_5566;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic add_byte(input logic [7:0] b);
    stim[n_stim] = b;
    n_stim++;
  endtask

  // reversed: least significant byte first
  task automatic add_word(input logic [31:0] w, input bit reversed);
    for (int b = 0; b < 4; b++)
      add_byte(reversed ? w[8*b +: 8] : w[8*(3-b) +: 8]);
  endtask

  function automatic logic [31:0] payload(input int i);
    return 32'h1020_3040 + 32'h0101_0101 * i;
  endfunction

  task automatic do_sof();
    @(negedge clk);
    in_sof = 1'b1; in_valid = 1'b1; in_data = 8'hFF;
    #1;
    chk("R11 ready low during sof", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    in_sof = 1'b0; in_valid = 1'b0;
    chk("R1 done cleared by sof", {31'd0, res_done}, 32'd0);
    chk("R1 swap cleared by sof", {31'd0, res_swapped}, 32'd0);
    n_stim = 0; n_got = 0; done_at = -1; swap_at = -1;
  endtask

  // called after a negedge; each byte is offered for exactly one edge
  task automatic send_all();
    for (int i = 0; i < n_stim; i++) begin
      in_valid = 1'b1; in_data = stim[i]; in_last = (i == n_stim - 1);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      if (res_done && done_at < 0) done_at = i;
      if (res_swapped && swap_at < 0) swap_at = i;
      if (out_valid && n_got < 16) begin
        got[n_got] = out_data;
        n_got++;
      end
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset done", {31'd0, res_done}, 32'd0);
    chk("R1 reset found", {31'd0, res_found}, 32'd0);
    chk("R1 reset swapped", {31'd0, res_swapped}, 32'd0);
    chk("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset ready", {31'd0, in_ready}, 32'd1);

    // R2 R3 R4 R6 R8: full header at offsets 0..4, both byte orders
    for (int sw = 0; sw < 2; sw++) begin
      for (int k = 0; k < 5; k++) begin
        do_sof();
        for (int p = 0; p < k; p++) add_byte(8'h00);
        for (int w = 0; w < 13; w++) add_word(exp_hdr(w), sw[0]);
        for (int w = 0; w < 3; w++) add_word(payload(w), sw[0]);
        add_byte(8'h77);
        send_all();
        chk("R2 done timing", done_at, k + 51);
        chk("R6 found only at offset zero", {31'd0, res_found}, (k == 0) ? 1 : 0);
        chk("R6 offset", {16'd0, res_offset}, k);
        chk("R4 swap flag", {31'd0, res_swapped}, sw);
        chk("R3 filler never swaps, swap timing", swap_at, sw ? k + 35 : -1);
        chk("R8 word count", n_got, (k == 0) ? 3 : 0);
        for (int w = 0; w < n_got && w < 3; w++)
          chk("R8 corrected word", got[w], payload(w));
        chk("R9 result held", {31'd0, res_done}, 32'd1);
      end
    end

    // R5: corrupted header word
    for (int sw = 0; sw < 2; sw++) begin
      for (int c = 0; c < 4; c++) begin
        int j;
        j = (c == 0) ? 1 : (c == 1) ? 8 : (c == 2) ? 9 : 12;
        do_sof();
        for (int w = 0; w < 13; w++) add_word(exp_hdr(w), sw[0]);
        stim[4*j] = stim[4*j] ^ 8'h5A;
        add_word(payload(0), sw[0]);
        send_all();
        chk("R5 fail timing", done_at, 4*j + 3);
        chk("R5 not found", {31'd0, res_found}, 32'd0);
        chk("R5 stalled", {31'd0, in_ready}, 32'd0);
        chk("R5 no output", n_got, 0);
      end
    end

    // R7: single attempt from first all-ones window
    do_sof();
    add_word(32'hFFFF_FFFF, 1'b0);
    add_word(32'h0000_0000, 1'b0);
    for (int w = 0; w < 13; w++) add_word(exp_hdr(w), 1'b0);
    send_all();
    chk("R7 single attempt fails", done_at, 7);
    chk("R7 not found", {31'd0, res_found}, 32'd0);
    chk("R7 offset", {16'd0, res_offset}, 0);

    // R10: stream ends inside header, and with no header at all
    do_sof();
    for (int w = 0; w < 5; w++) add_word(exp_hdr(w), 1'b0);
    send_all();
    chk("R10 early end timing", done_at, 19);
    chk("R10 early end not found", {31'd0, res_found}, 32'd0);
    do_sof();
    for (int p = 0; p < 6; p++) add_byte(8'h00);
    send_all();
    chk("R10 no header timing", done_at, 5);
    chk("R10 no header not found", {31'd0, res_found}, 32'd0);

    // R4: swap entered mid-header at word 9
    do_sof();
    for (int w = 0; w < 13; w++) add_word(exp_hdr(w), w >= 9);
    add_word(payload(5), 1'b1);
    send_all();
    chk("R4 late swap timing", swap_at, 39);
    chk("R4 late swap found", {31'd0, res_found}, 32'd1);
    chk("R8 late swap word", got[0], payload(5));

    finish_run();
  end

endmodule